// File: doc/BRIEF.md
# Combinational Device Truth-Table Dumper

This block reads the complete truth table of an external combinational logic device and sends it to a host over a serial line. It drives an 11-bit stimulus word onto the device's input pins and counts that word upward through every value, from 0 to 2047. After each new value it waits a programmable number of clock cycles for the device outputs to settle. It then samples the 7 response pins and transmits one byte per entry on an 8N1 UART line.

The stimulus bits are wired to the device as follows. Bits 0 to 2 drive three configuration-switch inputs. Bits 3 to 6 drive address lines 16 to 19. Bit 7 is a delayed memory strobe, bit 8 a refresh strobe, bit 9 a write strobe and bit 10 a read strobe.

The response bits are wired as follows. Bit 0 is the write enable and bit 1 the row strobe. Bit 2 is the data bus direction. Bits 3 to 5 are the column strobes of three banks, and bit 6 is a shared DRAM address bit 8.

A separate output enables the external level translator that brings the device outputs back into the chip. That enable is high only while a sweep runs. A press of the user button resets the block and starts a fresh dump, so the host can capture several passes and compare them.

Top module: `ttdump_top`

## Requirements
- R1: After reset the stimulus output is 0, the translator enable and the done flag are low, and the serial line is idle high.
- R2: A rising edge of the button input, after two synchronizer stages, starts a sweep at entry 0, raises the translator enable and clears the done flag.
- R3: During a sweep the stimulus word takes the values 0, 1, ..., 2047 in ascending order, and exactly one byte is sent per value, in that order, with no value skipped or repeated.
- R4: After each stimulus change the response is sampled exactly SETTLE_CYC clock cycles later, so a device whose outputs lag the stimulus by SETTLE_CYC-1 cycles is captured correctly.
- R5: Each transmitted byte holds response bits 6..0 in byte bits 6..0, and byte bit 7 is 0.
- R6: Each byte is framed as one start bit (0), eight data bits sent LSB first, and one stop bit (1). Each bit lasts BAUD_DIV clock cycles, and the line is 1 whenever no frame is in flight.
- R7: The stimulus advances on the same clock edge on which the transmitter accepts the previous entry's byte, and at no other time during a sweep.
- R8: After entry 2047 has been accepted, the stimulus returns to 0, the translator enable drops, done goes high, and the block transmits nothing further until the next button press.
- R9: A button press during a sweep aborts the frame in flight (the line returns high) and restarts the sweep at entry 0.
- R10: The translator enable is low whenever no sweep is running, including during reset and after completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| btn_i | input | 1 | User button, asynchronous, active high |
| stim_o | output | 11 | Stimulus word to the device inputs |
| resp_i | input | 7 | Device response pins |
| xlat_en_o | output | 1 | Level translator enable, active high |
| done_o | output | 1 | High after a complete sweep |
| txd_o | output | 1 | UART serial output, idle high |

## Verification
The bench builds the block with SETTLE_CYC = 3 and BAUD_DIV = 4. With these values a full 2048-entry pass fits in about 84,000 cycles, so every entry, the wrap at entry 2047 and the done state can be checked. The device model delays its response by SETTLE_CYC-1 cycles, which makes an early sample show up as a wrong byte. Because the transmitter is ten times slower than the settle window, every entry is held back by transmitter back-pressure, and a restart can be triggered in the middle of a start bit.

// File: rtl/ttdump_pkg.sv
// Package: shared types for the truth-table dumper.
// Assumes: nothing beyond IEEE 1800-2017.
package ttdump_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,   // no sweep, translator off
        ST_SETTLE = 2'd1,   // waiting for device outputs to settle
        ST_SEND   = 2'd2    // offering the sampled byte to the transmitter
    } dump_state_t;

    localparam int unsigned UART_BYTE_W = 8;

endpackage

// File: rtl/ttdump_btn.sv
// Module: button synchronizer and press detector.
// Two flip-flops bring the asynchronous button into the clock domain, and a third
// register turns its rising edge into a one-cycle pulse.
// Assumes: a press lasts longer than two clock periods. Bounce is not filtered.
module ttdump_btn (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_i,
    output logic press_o
);
    logic [2:0] sync_q;

    // Shift the button through the synchronizer and edge registers.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], btn_i};
    end

    assign press_o = sync_q[1] & ~sync_q[2];
endmodule

// File: rtl/ttdump_uart_tx.sv
// Module: 8N1 UART transmitter with a valid/ready byte input.
// Sends a start bit, DATA_W data bits LSB first and a stop bit, each BAUD_DIV
// clock cycles long. clr_i drops any frame in flight and returns the line high.
// Assumes: BAUD_DIV >= 1.
module ttdump_uart_tx #(
    parameter int unsigned BAUD_DIV = 104,
    parameter int unsigned DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              ready_o,
    output logic              txd_o
);
    localparam int unsigned FRAME_W = DATA_W + 2;
    localparam int unsigned BDIV_W  = (BAUD_DIV > 1) ? $clog2(BAUD_DIV) : 1;
    localparam int unsigned BIT_W   = $clog2(FRAME_W);
    localparam logic [BDIV_W-1:0] BDIV_LAST = BDIV_W'(BAUD_DIV - 1);
    localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(FRAME_W - 1);

    logic               busy_q;
    logic [FRAME_W-1:0] shift_q;
    logic [BDIV_W-1:0]  baud_q;
    logic [BIT_W-1:0]   bits_q;

    assign ready_o = ~busy_q;
    assign txd_o   = busy_q ? shift_q[0] : 1'b1;

    // Load a frame on accept, then shift one bit out every BAUD_DIV cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            busy_q  <= 1'b0;
            shift_q <= '1;
            baud_q  <= '0;
            bits_q  <= '0;
        end else if (!busy_q) begin
            if (valid_i) begin
                busy_q  <= 1'b1;
                shift_q <= {1'b1, data_i, 1'b0};
                baud_q  <= BDIV_LAST;
                bits_q  <= BIT_LAST;
            end
        end else if (baud_q != '0) begin
            baud_q <= baud_q - 1'b1;
        end else if (bits_q == '0) begin
            busy_q <= 1'b0;
        end else begin
            shift_q <= {1'b1, shift_q[FRAME_W-1:1]};
            bits_q  <= bits_q - 1'b1;
            baud_q  <= BDIV_LAST;
        end
    end
endmodule

// File: rtl/ttdump_seq.sv
// Module: sweep sequencer.
// Steps the stimulus through every value, waits SETTLE_CYC cycles after each
// change, captures the response and offers it as a byte. It advances only when
// the byte is accepted. start_i restarts the sweep from any state.
// Assumes: 1 <= SETTLE_CYC, OUT_W < 8.
module ttdump_seq
    import ttdump_pkg::*;
#(
    parameter int unsigned IN_W       = 11,
    parameter int unsigned OUT_W      = 7,
    parameter int unsigned SETTLE_CYC = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [OUT_W-1:0]       resp_i,
    input  logic                   tx_ready_i,
    output logic                   tx_valid_o,
    output logic [UART_BYTE_W-1:0] tx_data_o,
    output logic [IN_W-1:0]        stim_o,
    output logic                   xlat_en_o,
    output logic                   done_o
);
    localparam int unsigned CNT_W = $clog2(SETTLE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYC - 1);
    localparam logic [IN_W-1:0]  STIM_LAST = {IN_W{1'b1}};

    dump_state_t           state_q;
    logic [CNT_W-1:0]      cnt_q;
    logic [IN_W-1:0]       stim_q;
    logic [OUT_W-1:0]      samp_q;
    logic                  done_q;
    logic                  accept;

    assign accept     = (state_q == ST_SEND) && tx_ready_i;
    assign tx_valid_o = (state_q == ST_SEND);
    assign tx_data_o  = {{(UART_BYTE_W - OUT_W){1'b0}}, samp_q};
    assign stim_o     = stim_q;
    assign xlat_en_o  = (state_q != ST_IDLE);
    assign done_o     = done_q;

    // Sweep control: settle, capture, hand over, advance or finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            stim_q  <= '0;
            samp_q  <= '0;
            done_q  <= 1'b0;
        end else if (start_i) begin
            state_q <= ST_SETTLE;
            cnt_q   <= CNT_LOAD;
            stim_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_SETTLE: begin
                    if (cnt_q == '0) begin
                        samp_q  <= resp_i;
                        state_q <= ST_SEND;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_SEND: begin
                    if (accept) begin
                        if (stim_q == STIM_LAST) begin
                            stim_q  <= '0;
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            stim_q  <= stim_q + 1'b1;
                            cnt_q   <= CNT_LOAD;
                            state_q <= ST_SETTLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ttdump_top.sv
// Module: truth-table dumper top level.
// Joins the button detector, the sweep sequencer and the UART transmitter.
// A button press restarts the sequencer and clears the transmitter.
// Assumes: rst_n is synchronous to clk. btn_i may be asynchronous.
module ttdump_top #(
    parameter int unsigned IN_W       = 11,
    parameter int unsigned OUT_W      = 7,
    parameter int unsigned SETTLE_CYC = 16,
    parameter int unsigned BAUD_DIV   = 104
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             btn_i,
    output logic [IN_W-1:0]  stim_o,
    input  logic [OUT_W-1:0] resp_i,
    output logic             xlat_en_o,
    output logic             done_o,
    output logic             txd_o
);
    localparam int unsigned BYTE_W = ttdump_pkg::UART_BYTE_W;

    logic              start_pulse;
    logic              tx_valid;
    logic              tx_ready;
    logic              tx_fire;
    logic [BYTE_W-1:0] tx_data;

    assign tx_fire = tx_valid & tx_ready;

    ttdump_btn u_btn (
        .clk     (clk),
        .rst_n   (rst_n),
        .btn_i   (btn_i),
        .press_o (start_pulse)
    );

    ttdump_seq #(
        .IN_W       (IN_W),
        .OUT_W      (OUT_W),
        .SETTLE_CYC (SETTLE_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_pulse),
        .resp_i     (resp_i),
        .tx_ready_i (tx_ready),
        .tx_valid_o (tx_valid),
        .tx_data_o  (tx_data),
        .stim_o     (stim_o),
        .xlat_en_o  (xlat_en_o),
        .done_o     (done_o)
    );

    ttdump_uart_tx #(
        .BAUD_DIV (BAUD_DIV),
        .DATA_W   (BYTE_W)
    ) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (start_pulse),
        .valid_i (tx_valid),
        .data_i  (tx_data),
        .ready_o (tx_ready),
        .txd_o   (txd_o)
    );
endmodule

// File: rtl/ttdump_chk.sv
// Module: assertion checker for ttdump_top, attached by bind.
// Assumes: it observes the top's ports and its internal handshake nets.
module ttdump_chk #(
    parameter int unsigned IN_W = 11
) (
    input logic            clk,
    input logic            rst_n,
    input logic [IN_W-1:0] stim_o,
    input logic            xlat_en_o,
    input logic            done_o,
    input logic            txd_o,
    input logic            tx_ready,
    input logic            tx_fire,
    input logic            start_pulse
);
    // R3
    stim_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stim_o != $past(stim_o)) |-> ((stim_o == $past(stim_o) + 1'b1) || (stim_o == '0)));

    // R7
    stim_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stim_o != $past(stim_o)) |-> ($past(tx_fire) || $past(start_pulse)));

    // R8
    done_stim_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (stim_o == '0));

    // R10
    done_xlat_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !xlat_en_o);

    // R6
    line_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> txd_o);

    // R2
    start_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> (xlat_en_o && !done_o && (stim_o == '0)));
endmodule

bind ttdump_top ttdump_chk #(.IN_W(IN_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stim_o      (stim_o),
    .xlat_en_o   (xlat_en_o),
    .done_o      (done_o),
    .txd_o       (txd_o),
    .tx_ready    (tx_ready),
    .tx_fire     (tx_fire),
    .start_pulse (start_pulse)
);

// File: tb/test_ttdump_top.sv
// Bench: directed tests for ttdump_top with a delayed combinational device model
// and a serial receiver. One task per scenario, each checking its own results.
module test_ttdump_top;
    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned IN_W       = 11;
    localparam int unsigned OUT_W      = 7;
    localparam int unsigned SETTLE     = 3;
    localparam int unsigned DIV        = 4;
    localparam int unsigned ENTRIES    = 1 << IN_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             btn = 1'b0;
    logic [IN_W-1:0]  stim;
    logic [OUT_W-1:0] resp;
    logic             xlat_en;
    logic             done;
    logic             txd;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ttdump_top #(
        .IN_W(IN_W), .OUT_W(OUT_W), .SETTLE_CYC(SETTLE), .BAUD_DIV(DIV)
    ) i_ttdump_top (
        .clk(clk), .rst_n(rst_n), .btn_i(btn), .stim_o(stim),
        .resp_i(resp), .xlat_en_o(xlat_en), .done_o(done), .txd_o(txd)
    );

    // Device model: a fixed function of the stimulus, delayed by SETTLE-1 cycles.
    function automatic logic [OUT_W-1:0] dev_fn(input logic [IN_W-1:0] s);
        return s[6:0] ^ {s[10:7], s[9:7]};
    endfunction

    logic [OUT_W-1:0] dly1, dly2;
    always_ff @(posedge clk) begin
        dly1 <= dev_fn(stim);
        dly2 <= dly1;
    end
    assign resp = dly2;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Receive one frame. Also returns the stimulus seen when the start bit is detected.
    task automatic rx_byte(output logic [7:0] b, output logic [IN_W-1:0] st_at_start,
                           output bit frame_ok);
        frame_ok = 1'b1;
        @(negedge clk);
        while (txd !== 1'b0) @(negedge clk);
        st_at_start = stim;
        repeat (DIV/2) @(negedge clk);
        if (txd !== 1'b0) frame_ok = 1'b0;
        for (int i = 0; i < 8; i++) begin
            repeat (DIV) @(negedge clk);
            b[i] = txd;
        end
        repeat (DIV) @(negedge clk);
        if (txd !== 1'b1) frame_ok = 1'b0;
    endtask

    task automatic press_button();
        @(negedge clk);
        btn = 1'b1;
        repeat (4) @(negedge clk);
        btn = 1'b0;
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        check(stim == '0, "R1", "stim after reset", stim, 0);
        check(xlat_en == 1'b0, "R1", "xlat_en after reset", xlat_en, 0);
        check(done == 1'b0, "R1", "done after reset", done, 0);
        check(txd == 1'b1, "R1", "txd after reset", txd, 1);
    endtask

    task automatic t_idle_quiet();
        bit saw_low = 1'b0;
        bit saw_en = 1'b0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) saw_low = 1'b1;
            if (xlat_en !== 1'b0) saw_en = 1'b1;
        end
        check(!saw_low, "R6", "line idle before start", saw_low, 0);
        check(!saw_en, "R10", "translator off while idle", saw_en, 0);
    endtask

    // R2, R9: start a sweep, take a few bytes, then restart mid start bit.
    task automatic t_start_and_abort();
        logic [7:0] b;
        logic [IN_W-1:0] st;
        bit ok;
        press_button();
        @(negedge clk);
        check(xlat_en == 1'b1, "R2", "xlat_en after press", xlat_en, 1);
        check(done == 1'b0, "R2", "done after press", done, 0);
        for (int k = 0; k < 5; k++) begin
            rx_byte(b, st, ok);
            check(ok && b == {1'b0, dev_fn(IN_W'(k))}, "R2", "early byte", b, dev_fn(IN_W'(k)));
        end
        @(negedge clk);
        while (txd !== 1'b0) @(negedge clk);
        btn = 1'b1;
        repeat (4) @(negedge clk);
        btn = 1'b0;
        check(txd == 1'b1, "R9", "frame aborted by press", txd, 1);
        check(stim == '0, "R9", "stim back to 0 after press", stim, 0);
    endtask

    // R3, R4, R5, R6, R7: one full pass, every entry checked.
    task automatic t_full_pass();
        logic [7:0] b;
        logic [IN_W-1:0] st;
        bit ok;
        int bad_data = 0;
        int bad_step = 0;
        int bad_en = 0;
        for (int k = 0; k < ENTRIES; k++) begin
            logic [IN_W-1:0] exp_st;
            rx_byte(b, st, ok);
            exp_st = (k == ENTRIES - 1) ? '0 : IN_W'(k + 1);
            if (k < ENTRIES - 1 && xlat_en !== 1'b1) bad_en++;
            if (!(ok && b == {1'b0, dev_fn(IN_W'(k))})) begin
                bad_data++;
                if (bad_data < 5)
                    check(1'b0, "R4", $sformatf("byte %0d", k), b, {1'b0, dev_fn(IN_W'(k))});
            end
            if (st != exp_st) begin
                bad_step++;
                if (bad_step < 5)
                    check(1'b0, "R7", $sformatf("stim at start of byte %0d", k), st, exp_st);
            end
        end
        check(bad_data == 0, "R3", "entries matching in order (R5 bit 7 zero, R6 framing)", bad_data, 0);
        check(bad_step == 0, "R7", "stim advanced at each accept", bad_step, 0);
        check(bad_en == 0, "R10", "translator on during sweep", bad_en, 0);
    endtask

    // R8: after the last entry the block rests with done set.
    task automatic t_done_hold();
        bit saw_low = 1'b0;
        @(negedge clk);
        check(done == 1'b1, "R8", "done after pass", done, 1);
        check(xlat_en == 1'b0, "R8", "xlat_en after pass", xlat_en, 0);
        check(stim == '0, "R8", "stim after pass", stim, 0);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) saw_low = 1'b1;
        end
        check(!saw_low, "R8", "no transmission after done", saw_low, 0);
        check(done == 1'b1, "R8", "done held", done, 1);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_idle_quiet();
        t_start_and_abort();
        t_full_pass();
        t_done_hold();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL R3 watchdog: actual %0d cycles expected completion", 195000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule